// File: doc/BRIEF.md
# Data-Available Strobe and Overflow Controller

This block sits between a radio data decoder and the register interface a host uses to collect the decoded blocks. It watches the decoder's events: a block was processed, the block was a correct A-block, synchronization was found, synchronization was lost, and a reset was detected. From these it decides when the output holding registers take new data. It then raises an active-low strobe telling the host that fresh data is waiting.

A 2-bit control chooses between three reporting modes. Mode 00 reports every block once synchronized. Mode 01 also reports correct A-blocks during the search, for quick identification of a station. Mode 10 reports every second block once synchronized. Code 11 reports only the forced events. The strobe releases after a fixed number of millisecond ticks, or at once when the host finishes a read. Data stays frozen for a minimum window so the host can read it. If the host falls behind while the decoder is synchronized, an overflow flag freezes the registers until a complete read clears it.

All timing counts a one-cycle `tick_ms` pulse, so the block does not depend on the clock frequency.

Top module: `rdy_strobe_ctrl`

## Requirements
- R1: After reset `ready_n` is 1, `ovf_flag` is 0 and `load_regs` is 0 while no event input is active.
- R2: Mode 00 loads nothing on blocks while `in_sync` is 0. While `in_sync` is 1, every `blk_done` pulse loads, provided it is not gated by R8 or R9.
- R3: Mode 01 loads on a `blk_done` with `blk_is_a`=1 while `in_sync` is 0, and ignores other blocks during search. While `in_sync` is 1 it loads on every block, as in mode 00.
- R4: Mode 10 loads on every second accepted block while `in_sync` is 1. The pair count restarts whenever `in_sync` is 0 or `sync_found` pulses.
- R5: In every mode a `sync_found`, `sync_lost` or `rst_seen` pulse loads the registers and starts the strobe, unless an overflow is pending.
- R6: The strobe releases on the STROBE_MS-th `tick_ms` after a load (default 10).
- R7: A `rd_done` pulse without a simultaneous load sets `ready_n` to 1 on the following cycle.
- R8: Blocks are ignored from a load until either a `rd_done` arrives or HOLD_MS ticks have passed (default 20), even after the strobe has timed out.
- R9: A `blk_done` while `in_sync` is 1 and the last load is still unread sets `ovf_flag` and does not load. While `ovf_flag` is 1 no input causes a load, until `rd_done` clears the flag.
- R10: When `rd_done` and `blk_done` fall in the same cycle, the read is taken first. No overflow is flagged, and the block is judged against the cleared state.
- R11: Mode 11 never loads on `blk_done`.
- R12: `ready_n` goes low on the cycle after the `load_regs` pulse, so the data is valid before the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| mode | input | 2 | Reporting mode: 00 every block, 01 A-block search, 10 every second block, 11 forced events only |
| in_sync | input | 1 | Decoder is synchronized |
| blk_done | input | 1 | A block was processed (pulse) |
| blk_is_a | input | 1 | The processed block is a correct A-block |
| sync_found | input | 1 | Synchronization acquired (pulse) |
| sync_lost | input | 1 | Flywheel signalled loss of synchronization (pulse) |
| rst_seen | input | 1 | Power-on or voltage-drop reset detected (pulse) |
| rd_done | input | 1 | Host completed a full read of the output registers (pulse) |
| load_regs | output | 1 | Load enable for the output holding registers, same cycle as the event |
| ready_n | output | 1 | Active-low data-available strobe |
| ovf_flag | output | 1 | Data overflow: host fell behind, registers frozen |

## Verification
A host read and a new synchronized block can land in the same cycle. On its own each would do something different: the block would raise an overflow against unread data, and the read would release the strobe. The bench loads one block, then drives `rd_done` and `blk_done` together on one edge. It expects `load_regs` high in that cycle, `ovf_flag` still low afterwards and the strobe re-asserted. The overflow scenario, with the block alone and no read, gives the contrasting case.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

  typedef enum logic [1:0] {
    RPT_EVERY  = 2'b00,
    RPT_APROBE = 2'b01,
    RPT_PAIR   = 2'b10,
    RPT_NONE   = 2'b11
  } rpt_mode_e;

  // Does an accepted block produce a report in this mode and sync state?
  function automatic logic blk_reports(rpt_mode_e m, logic sync, logic is_a,
                                       logic second);
    case (m)
      RPT_EVERY:  return sync;
      RPT_APROBE: return sync | is_a;
      RPT_PAIR:   return sync & second;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rdy_evt_qual.sv
module rdy_evt_qual
  import rdy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       in_sync,
  input  logic       blk_done,
  input  logic       blk_is_a,
  input  logic       sync_found,
  input  logic       sync_lost,
  input  logic       rst_seen,
  input  logic       gate_blk,
  input  logic       gate_all,
  output logic       fire
);

  rpt_mode_e m;
  logic      half_q;
  logic      blk_ok;
  logic      blk_fire;
  logic      forced;

  assign m        = rpt_mode_e'(mode);
  assign blk_ok   = blk_done & ~gate_blk;
  assign blk_fire = blk_ok & blk_reports(m, in_sync, blk_is_a, half_q);
  assign forced   = (sync_found | sync_lost | rst_seen) & ~gate_all;
  assign fire     = blk_fire | forced;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
    end else if (!in_sync || m != RPT_PAIR || sync_found) begin
      half_q <= 1'b0;
    end else if (blk_ok) begin
      half_q <= ~half_q;
    end
  end

endmodule

// File: rtl/rdy_timer.sv
module rdy_timer #(
  parameter int STROBE_MS = 10,
  parameter int HOLD_MS   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic load,
  input  logic rd_done,
  output logic strobe_on,
  output logic pend_on,
  output logic hold_on
);

  localparam int AGE_W = $clog2(HOLD_MS + 1);
  localparam logic [AGE_W-1:0] HOLD_L   = AGE_W'(HOLD_MS);
  localparam logic [AGE_W-1:0] STR_LAST = AGE_W'(STROBE_MS - 1);

  logic [AGE_W-1:0] age_q;
  logic             strobe_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q    <= HOLD_L;
      strobe_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (load) begin
      age_q    <= '0;
      strobe_q <= 1'b1;
      pend_q   <= 1'b1;
    end else begin
      if (tick_ms && age_q < HOLD_L) age_q <= age_q + 1'b1;
      if (tick_ms && age_q == STR_LAST) strobe_q <= 1'b0;
      if (rd_done) begin
        strobe_q <= 1'b0;
        pend_q   <= 1'b0;
      end
    end
  end

  assign strobe_on = strobe_q;
  assign pend_on   = pend_q;
  assign hold_on   = pend_q & (age_q < HOLD_L);

endmodule

// File: rtl/rdy_ovf.sv
module rdy_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_done,
  input  logic in_sync,
  input  logic pend_on,
  input  logic rd_done,
  output logic ovf_hit,
  output logic ovf_on
);

  logic ovf_q;

  assign ovf_hit = blk_done & in_sync & pend_on & ~rd_done;

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (rd_done) ovf_q <= 1'b0;
    else if (ovf_hit) ovf_q <= 1'b1;
  end

  assign ovf_on = ovf_q;

endmodule

// File: rtl/rdy_strobe_ctrl.sv
module rdy_strobe_ctrl #(
  parameter int STROBE_MS = 10,
  parameter int HOLD_MS   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic [1:0] mode,
  input  logic       in_sync,
  input  logic       blk_done,
  input  logic       blk_is_a,
  input  logic       sync_found,
  input  logic       sync_lost,
  input  logic       rst_seen,
  input  logic       rd_done,
  output logic       load_regs,
  output logic       ready_n,
  output logic       ovf_flag
);

  logic strobe_on;
  logic pend_on;
  logic hold_on;
  logic ovf_hit;
  logic ovf_on;
  logic gate_all;
  logic gate_blk;
  logic fire;

  // A read in the same cycle is applied before any block is judged.
  assign gate_all = (ovf_on & ~rd_done) | ovf_hit;
  assign gate_blk = gate_all | (~rd_done & (hold_on | (in_sync & pend_on)));

  rdy_evt_qual i_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .in_sync   (in_sync),
    .blk_done  (blk_done),
    .blk_is_a  (blk_is_a),
    .sync_found(sync_found),
    .sync_lost (sync_lost),
    .rst_seen  (rst_seen),
    .gate_blk  (gate_blk),
    .gate_all  (gate_all),
    .fire      (fire)
  );

  rdy_timer #(.STROBE_MS(STROBE_MS), .HOLD_MS(HOLD_MS)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_ms  (tick_ms),
    .load     (fire),
    .rd_done  (rd_done),
    .strobe_on(strobe_on),
    .pend_on  (pend_on),
    .hold_on  (hold_on)
  );

  rdy_ovf i_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk_done(blk_done),
    .in_sync (in_sync),
    .pend_on (pend_on),
    .rd_done (rd_done),
    .ovf_hit (ovf_hit),
    .ovf_on  (ovf_on)
  );

  assign load_regs = fire;
  assign ready_n   = ~strobe_on;
  assign ovf_flag  = ovf_on;

endmodule

// File: rtl/rdy_strobe_chk.sv
module rdy_strobe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       in_sync,
  input logic       blk_done,
  input logic       sync_found,
  input logic       sync_lost,
  input logic       rst_seen,
  input logic       rd_done,
  input logic       load_regs,
  input logic       ready_n,
  input logic       ovf_flag
);

  logic any_forced;
  assign any_forced = sync_found | sync_lost | rst_seen;

  // R12
  strobe_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_regs |=> !ready_n);

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !load_regs) |=> ready_n);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !rd_done) |-> !load_regs);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(blk_done && in_sync));

  // R10
  read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !ovf_flag);

  // R11
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !any_forced) |-> !load_regs);

  // R2
  search_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !in_sync && !any_forced) |-> !load_regs);

endmodule

bind rdy_strobe_ctrl rdy_strobe_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .in_sync   (in_sync),
  .blk_done  (blk_done),
  .sync_found(sync_found),
  .sync_lost (sync_lost),
  .rst_seen  (rst_seen),
  .rd_done   (rd_done),
  .load_regs (load_regs),
  .ready_n   (ready_n),
  .ovf_flag  (ovf_flag)
);

// File: tb/test_rdy_strobe_ctrl.sv
module test_rdy_strobe_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_ms;
  logic [1:0] mode;
  logic       in_sync;
  logic       blk_done;
  logic       blk_is_a;
  logic       sync_found;
  logic       sync_lost;
  logic       rst_seen;
  logic       rd_done;
  logic       load_regs;
  logic       ready_n;
  logic       ovf_flag;

  int n_chk  = 0;
  int n_fail = 0;
  logic ld;

  always #10 clk = ~clk;

  rdy_strobe_ctrl i_rdy_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .mode(mode),
    .in_sync(in_sync), .blk_done(blk_done), .blk_is_a(blk_is_a),
    .sync_found(sync_found), .sync_lost(sync_lost), .rst_seen(rst_seen),
    .rd_done(rd_done), .load_regs(load_regs), .ready_n(ready_n),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_ms = 0; mode = 2'b00; in_sync = 0; blk_done = 0;
    blk_is_a = 0; sync_found = 0; sync_lost = 0; rst_seen = 0; rd_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Pulse a block for one cycle; ld captures load_regs in that cycle.
  task automatic blk(input logic is_a, input logic with_rd, output logic l);
    @(negedge clk);
    blk_done = 1; blk_is_a = is_a; rd_done = with_rd;
    #2 l = load_regs;
    @(negedge clk);
    blk_done = 0; blk_is_a = 0; rd_done = 0;
  endtask

  task automatic forced(input int kind, output logic l);
    @(negedge clk);
    case (kind)
      0: sync_found = 1;
      1: sync_lost = 1;
      default: rst_seen = 1;
    endcase
    #2 l = load_regs;
    @(negedge clk);
    sync_found = 0; sync_lost = 0; rst_seen = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_ms = 1;
      @(negedge clk); tick_ms = 0;
    end
  endtask

  task automatic host_read();
    @(negedge clk); rd_done = 1;
    @(negedge clk); rd_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ready_n after reset", ready_n, 1'b1);
    chk("R1 ovf_flag after reset", ovf_flag, 1'b0);
    chk("R1 load_regs idle", load_regs, 1'b0);
  endtask

  task automatic t_standard();
    do_reset();
    blk(0, 0, ld);
    chk("R2 search block no load", ld, 1'b0);
    chk("R2 search strobe idle", ready_n, 1'b1);
    in_sync = 1;
    blk(0, 0, ld);
    chk("R2 sync block loads", ld, 1'b1);
    chk("R12 strobe low after load", ready_n, 1'b0);
    host_read();
    chk("R7 read releases strobe", ready_n, 1'b1);
    blk(0, 0, ld);
    chk("R2 next block loads", ld, 1'b1);
  endtask

  task automatic t_timeout();
    do_reset();
    in_sync = 1;
    blk(0, 0, ld);
    ticks(9);
    chk("R6 strobe held before limit", ready_n, 1'b0);
    ticks(1);
    chk("R6 strobe released at limit", ready_n, 1'b1);
  endtask

  task automatic t_fastpi();
    do_reset();
    mode = 2'b01;
    blk(0, 0, ld);
    chk("R3 non-A search ignored", ld, 1'b0);
    blk(1, 0, ld);
    chk("R3 A-block search loads", ld, 1'b1);
    chk("R3 strobe on A-block", ready_n, 1'b0);
    ticks(10);
    chk("R6 strobe timed out", ready_n, 1'b1);
    blk(1, 0, ld);
    chk("R8 hold window blocks load", ld, 1'b0);
    ticks(10);
    blk(1, 0, ld);
    chk("R8 load after hold window", ld, 1'b1);
    host_read();
    in_sync = 1;
    blk(0, 0, ld);
    chk("R3 sync non-A loads", ld, 1'b1);
  endtask

  task automatic t_pair();
    do_reset();
    mode = 2'b10;
    blk(0, 0, ld);
    chk("R4 search ignored", ld, 1'b0);
    in_sync = 1;
    blk(0, 0, ld);
    chk("R4 first of pair no load", ld, 1'b0);
    blk(0, 0, ld);
    chk("R4 second of pair loads", ld, 1'b1);
    chk("R4 strobe on pair", ready_n, 1'b0);
    host_read();
    blk(0, 0, ld);
    chk("R4 new pair first", ld, 1'b0);
    @(negedge clk); in_sync = 0;
    @(negedge clk); in_sync = 1;
    blk(0, 0, ld);
    chk("R4 count restarted", ld, 1'b0);
    blk(0, 0, ld);
    chk("R4 restarted pair loads", ld, 1'b1);
  endtask

  task automatic t_forced();
    do_reset();
    mode = 2'b11;
    in_sync = 1;
    blk(0, 0, ld);
    chk("R11 mode 11 block ignored", ld, 1'b0);
    forced(1, ld);
    chk("R5 sync lost loads", ld, 1'b1);
    chk("R5 sync lost strobe", ready_n, 1'b0);
    host_read();
    forced(2, ld);
    chk("R5 reset seen loads", ld, 1'b1);
    host_read();
    forced(0, ld);
    chk("R5 sync found loads", ld, 1'b1);
  endtask

  task automatic t_overflow();
    do_reset();
    in_sync = 1;
    blk(0, 0, ld);
    blk(0, 0, ld);
    chk("R9 unread block not loaded", ld, 1'b0);
    chk("R9 overflow set", ovf_flag, 1'b1);
    ticks(25);
    blk(0, 0, ld);
    chk("R9 frozen after windows", ld, 1'b0);
    chk("R9 overflow held", ovf_flag, 1'b1);
    forced(1, ld);
    chk("R9 forced event frozen", ld, 1'b0);
    host_read();
    chk("R9 read clears overflow", ovf_flag, 1'b0);
    blk(0, 0, ld);
    chk("R9 load after clear", ld, 1'b1);
  endtask

  task automatic t_collide();
    do_reset();
    in_sync = 1;
    blk(0, 0, ld);
    blk(0, 1, ld);
    chk("R10 read and block loads", ld, 1'b1);
    chk("R10 no overflow", ovf_flag, 1'b0);
    chk("R10 strobe re-asserted", ready_n, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    summary();
  end

  initial begin
    t_reset();
    t_standard();
    t_timeout();
    t_fastpi();
    t_pair();
    t_forced();
    t_overflow();
    t_collide();
    summary();
  end

endmodule